// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Controller

This block lets the two ports of a shared memory, called left and right, signal each other. The two highest addresses of the array act as mailboxes and each one has a fixed owner. The highest address belongs to the right port and the next one down belongs to the left port. When a port writes into the mailbox owned by the other port, the owner's interrupt line goes active. The owner clears it by reading its own mailbox.

The block only decodes addresses and holds the two interrupt flags. Storing the mailbox data and arbitrating between the ports are done elsewhere. Port accesses are sampled on the rising clock edge, so an interrupt output changes one clock after the access that caused the change. The address width `AW` is a parameter, with a default of 17 (128K entries).

Top module: `mbx_irq_ctrl`

## Requirements
- R1: After reset both interrupt outputs are high (inactive). Both outputs are active-low.
- R2: A left-port write to address 2^AW-1 drives `r_irq_n` low on the clock after the write is sampled.
- R3: A right-port write to address 2^AW-2 drives `l_irq_n` low on the clock after the write is sampled.
- R4: A right-port read of address 2^AW-1 drives `r_irq_n` high one clock later.
- R5: A left-port read of address 2^AW-2 drives `l_irq_n` high one clock later.
- R6: A write by a port to its own mailbox changes neither interrupt. That is a left write to 2^AW-2, or a right write to 2^AW-1.
- R7: If a set and a clear of the same interrupt are sampled on the same edge, the interrupt ends up active.
- R8: An access counts only when that port's `*_ce_n` is low. A write requires `*_rw_n` low. A read requires `*_rw_n` high and `*_oe_n` low. Unqualified accesses have no effect.
- R9: A read of a mailbox by the port that does not own it leaves both interrupts unchanged. A write by the non-owner leaves the other interrupt unchanged.
- R10: Only the two top addresses for the configured `AW` are mailboxes. Any other address, including 2^(AW-1)-1 and 2^AW-3, has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; accesses are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| l_ce_n | input | 1 | Left port chip enable, active low |
| l_rw_n | input | 1 | Left port direction: 0 write, 1 read |
| l_oe_n | input | 1 | Left port output enable, active low |
| l_addr | input | AW | Left port address |
| r_ce_n | input | 1 | Right port chip enable, active low |
| r_rw_n | input | 1 | Right port direction: 0 write, 1 read |
| r_oe_n | input | 1 | Right port output enable, active low |
| r_addr | input | AW | Right port address |
| l_irq_n | output | 1 | Left port interrupt, active low |
| r_irq_n | output | 1 | Right port interrupt, active low |

## Verification
Each interrupt flag is a single bit that the outputs show directly. A flag that is wrongly set, cleared or held therefore shows as a wrong level on `l_irq_n` or `r_irq_n` one clock after the access that caused it. An error can also come from a mailbox address or access qualifier that is decoded wrongly. It may stay hidden until a later access lands on the wrong flag, but it still shows on the clock that follows that access. For this reason the outputs are compared with a reference model on every cycle, both in directed sequences and in a long mixed run.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  typedef enum logic {
    SIDE_LEFT  = 1'b0,
    SIDE_RIGHT = 1'b1
  } side_e;

  // Mailbox location owned by a side: the right side owns the top entry,
  // the left side owns the entry just below it.
  function automatic logic [31:0] mbx_addr(input int aw, input side_e owner);
    logic [63:0] span;
    span = 64'd1 << aw;
    if (owner == SIDE_RIGHT) return span[31:0] - 32'd1;
    else                     return span[31:0] - 32'd2;
  endfunction

  function automatic logic acc_write(input logic ce_n, input logic rw_n);
    return !ce_n && !rw_n;
  endfunction

  function automatic logic acc_read(input logic ce_n, input logic rw_n,
                                    input logic oe_n);
    return !ce_n && rw_n && !oe_n;
  endfunction

endpackage

// File: rtl/mbx_port_decode.sv
module mbx_port_decode
  import mbx_pkg::*;
#(
  parameter int    AW   = 17,
  parameter side_e SIDE = SIDE_LEFT
) (
  input  logic          ce_n,
  input  logic          rw_n,
  input  logic          oe_n,
  input  logic [AW-1:0] addr,
  output logic          wr_peer,
  output logic          rd_own
);
  localparam side_e       PEER     = (SIDE == SIDE_LEFT) ? SIDE_RIGHT : SIDE_LEFT;
  localparam logic [31:0] OWN_FULL  = mbx_addr(AW, SIDE);
  localparam logic [31:0] PEER_FULL = mbx_addr(AW, PEER);
  localparam logic [AW-1:0] OWN_A  = OWN_FULL[AW-1:0];
  localparam logic [AW-1:0] PEER_A = PEER_FULL[AW-1:0];

  logic is_wr, is_rd;

  always_comb begin
    is_wr   = acc_write(ce_n, rw_n);
    is_rd   = acc_read(ce_n, rw_n, oe_n);
    wr_peer = is_wr && (addr == PEER_A);
    rd_own  = is_rd && (addr == OWN_A);
  end
endmodule

// File: rtl/mbx_irq_flag.sv
module mbx_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr_evt,
  output logic irq_n
);
  logic pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       pend_q <= 1'b0;
    else if (set_evt) pend_q <= 1'b1;
    else if (clr_evt) pend_q <= 1'b0;
  end

  assign irq_n = ~pend_q;
endmodule

// File: rtl/mbx_irq_ctrl.sv
module mbx_irq_ctrl
  import mbx_pkg::*;
#(
  parameter int AW = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          l_ce_n,
  input  logic          l_rw_n,
  input  logic          l_oe_n,
  input  logic [AW-1:0] l_addr,
  input  logic          r_ce_n,
  input  logic          r_rw_n,
  input  logic          r_oe_n,
  input  logic [AW-1:0] r_addr,
  output logic          l_irq_n,
  output logic          r_irq_n
);
  localparam int NSIDE = 2;

  logic [NSIDE-1:0]         ce_n_v, rw_n_v, oe_n_v;
  logic [NSIDE-1:0][AW-1:0] addr_v;
  logic [NSIDE-1:0]         wr_peer_v, rd_own_v;
  // Named events per owning side (index 0 left, 1 right) for the checker.
  logic [NSIDE-1:0]         set_evt, clr_evt;
  logic [NSIDE-1:0]         irq_n_v;

  assign ce_n_v = {r_ce_n, l_ce_n};
  assign rw_n_v = {r_rw_n, l_rw_n};
  assign oe_n_v = {r_oe_n, l_oe_n};
  assign addr_v = {r_addr, l_addr};

  for (genvar s = 0; s < NSIDE; s++) begin : g_side
    mbx_port_decode #(
      .AW   (AW),
      .SIDE (side_e'(s))
    ) u_dec (
      .ce_n    (ce_n_v[s]),
      .rw_n    (rw_n_v[s]),
      .oe_n    (oe_n_v[s]),
      .addr    (addr_v[s]),
      .wr_peer (wr_peer_v[s]),
      .rd_own  (rd_own_v[s])
    );

    // A side's flag is set by the other side writing to it, cleared by itself.
    assign set_evt[s] = wr_peer_v[NSIDE-1-s];
    assign clr_evt[s] = rd_own_v[s];

    mbx_irq_flag u_flag (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_evt (set_evt[s]),
      .clr_evt (clr_evt[s]),
      .irq_n   (irq_n_v[s])
    );
  end

  assign l_irq_n = irq_n_v[0];
  assign r_irq_n = irq_n_v[1];
endmodule

// File: rtl/mbx_irq_ctrl_chk.sv
module mbx_irq_ctrl_chk #(
  parameter int AW = 17
) (
  input logic          clk,
  input logic          rst_n,
  input logic          l_ce_n,
  input logic          l_rw_n,
  input logic          l_oe_n,
  input logic [AW-1:0] l_addr,
  input logic          r_ce_n,
  input logic          r_rw_n,
  input logic          r_oe_n,
  input logic [AW-1:0] r_addr,
  input logic          l_irq_n,
  input logic          r_irq_n,
  input logic [1:0]    set_evt,
  input logic [1:0]    clr_evt
);
  localparam logic [AW-1:0] TOP = '1;
  localparam logic [AW-1:0] SUB = TOP - 1'b1;

  logic l_wr, l_rd, r_wr, r_rd;
  assign l_wr = !l_ce_n && !l_rw_n;
  assign l_rd = !l_ce_n && l_rw_n && !l_oe_n;
  assign r_wr = !r_ce_n && !r_rw_n;
  assign r_rd = !r_ce_n && r_rw_n && !r_oe_n;

  // R2 and R7: a left write to the top entry wins over any clear
  a_r2_left_sets_right: assert property (@(posedge clk) disable iff (!rst_n)
    (l_wr && l_addr == TOP) |=> !r_irq_n);

  // R3 and R7
  a_r3_right_sets_left: assert property (@(posedge clk) disable iff (!rst_n)
    (r_wr && r_addr == SUB) |=> !l_irq_n);

  a_r4_owner_clears_right: assert property (@(posedge clk) disable iff (!rst_n)
    (r_rd && r_addr == TOP && !(l_wr && l_addr == TOP)) |=> r_irq_n);

  a_r5_owner_clears_left: assert property (@(posedge clk) disable iff (!rst_n)
    (l_rd && l_addr == SUB && !(r_wr && r_addr == SUB)) |=> l_irq_n);

  a_r6_own_write_no_set: assert property (@(posedge clk) disable iff (!rst_n)
    ((l_wr && l_addr == SUB) || (r_wr && r_addr == TOP)) |->
      (!set_evt[0] || (r_wr && r_addr == SUB)) && (!set_evt[1] || (l_wr && l_addr == TOP)));

  a_r9_right_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_evt[1] && !clr_evt[1]) |=> $stable(r_irq_n));

  a_r9_left_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_evt[0] && !clr_evt[0]) |=> $stable(l_irq_n));
endmodule

bind mbx_irq_ctrl mbx_irq_ctrl_chk #(.AW(AW)) u_chk (.*);

// File: tb/mbx_irq_ctrl_test.sv
module mbx_irq_ctrl_test;
  localparam int CLK_P = 10;
  localparam int AW = 17;
  localparam logic [AW-1:0] TOP = 17'h1FFFF;
  localparam logic [AW-1:0] SUB = 17'h1FFFE;

  // op codes: 0 idle, 1 write, 2 read, 3 write with ce_n high,
  //           4 read with oe_n high, 5 read with ce_n high
  localparam int OP_IDLE = 0, OP_WR = 1, OP_RD = 2, OP_WR_NOCE = 3,
                 OP_RD_NOOE = 4, OP_RD_NOCE = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic l_ce_n = 1'b1, l_rw_n = 1'b1, l_oe_n = 1'b1;
  logic r_ce_n = 1'b1, r_rw_n = 1'b1, r_oe_n = 1'b1;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic l_irq_n, r_irq_n;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 0;
  bit exp_l_pend = 0, exp_r_pend = 0;
  string last_req = "R1";

  always #(CLK_P/2) clk = ~clk;

  mbx_irq_ctrl #(.AW(AW)) uut (
    .clk(clk), .rst_n(rst_n),
    .l_ce_n(l_ce_n), .l_rw_n(l_rw_n), .l_oe_n(l_oe_n), .l_addr(l_addr),
    .r_ce_n(r_ce_n), .r_rw_n(r_rw_n), .r_oe_n(r_oe_n), .r_addr(r_addr),
    .l_irq_n(l_irq_n), .r_irq_n(r_irq_n)
  );

  task automatic pins(input int op, output logic ce_n, output logic rw_n,
                      output logic oe_n);
    ce_n = 1'b1; rw_n = 1'b1; oe_n = 1'b1;
    case (op)
      OP_WR:      begin ce_n = 1'b0; rw_n = 1'b0; end
      OP_RD:      begin ce_n = 1'b0; oe_n = 1'b0; end
      OP_WR_NOCE: begin rw_n = 1'b0; end
      OP_RD_NOOE: begin ce_n = 1'b0; end
      OP_RD_NOCE: begin oe_n = 1'b0; end
      default: ;
    endcase
  endtask

  task automatic compare();
    n_run++;
    if (l_irq_n !== !exp_l_pend || r_irq_n !== !exp_r_pend) begin
      n_fail++;
      $display("FAIL %s: l_irq_n=%b r_irq_n=%b expected l_irq_n=%b r_irq_n=%b",
               last_req, l_irq_n, r_irq_n, !exp_l_pend, !exp_r_pend);
    end
  endtask

  // Compare outputs for the previous cycle, then apply one cycle of accesses
  // and advance the reference model at the clock edge.
  task automatic step(input int lop, input logic [AW-1:0] la,
                      input int rop, input logic [AW-1:0] ra, input string req);
    logic c, w, o;
    @(negedge clk);
    compare();
    pins(lop, c, w, o); l_ce_n = c; l_rw_n = w; l_oe_n = o; l_addr = la;
    pins(rop, c, w, o); r_ce_n = c; r_rw_n = w; r_oe_n = o; r_addr = ra;
    last_req = req;
    @(posedge clk);
    if (!rst_n) begin
      exp_l_pend = 0; exp_r_pend = 0;
    end else begin
      if (lop == OP_WR && la == TOP) exp_r_pend = 1;
      else if (rop == OP_RD && ra == TOP) exp_r_pend = 0;
      if (rop == OP_WR && ra == SUB) exp_l_pend = 1;
      else if (lop == OP_RD && la == SUB) exp_l_pend = 0;
    end
  endtask

  function automatic logic [AW-1:0] pick_addr();
    int k;
    k = $urandom_range(0, 3);
    if (k == 0) return TOP;
    if (k == 1) return SUB;
    if (k == 2) return TOP - 17'd2;
    return AW'($urandom);
  endfunction

  initial begin
    #(CLK_P * 50000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    last_req = "R1";
    exp_l_pend = 0; exp_r_pend = 0;
    step(OP_IDLE, '0, OP_IDLE, '0, "R1");          // reset state compared here
    step(OP_WR, TOP, OP_IDLE, '0, "R2");           // left sets right irq
    step(OP_IDLE, '0, OP_RD, SUB, "R9");           // right reads left mailbox
    step(OP_RD, TOP, OP_IDLE, '0, "R9");           // left reads right mailbox
    step(OP_IDLE, '0, OP_RD, TOP, "R4");           // right clears its irq
    step(OP_IDLE, '0, OP_WR, SUB, "R3");           // right sets left irq
    step(OP_RD, SUB, OP_IDLE, '0, "R5");           // left clears its irq
    step(OP_WR, SUB, OP_IDLE, '0, "R6");           // left writes own mailbox
    step(OP_IDLE, '0, OP_WR, TOP, "R6");           // right writes own mailbox
    step(OP_WR_NOCE, TOP, OP_WR_NOCE, SUB, "R8");  // writes without chip enable
    step(OP_RD, TOP, OP_RD, SUB, "R8");            // reads are not writes
    step(OP_WR, TOP, OP_WR, SUB, "R2");            // set both
    step(OP_RD_NOOE, SUB, OP_RD_NOOE, TOP, "R8");  // reads without oe
    step(OP_RD_NOCE, SUB, OP_RD_NOCE, TOP, "R8");  // reads without ce
    step(OP_IDLE, '0, OP_IDLE, '0, "R8");
    step(OP_WR, TOP, OP_RD, TOP, "R7");            // set and clear together
    step(OP_RD, SUB, OP_WR, SUB, "R7");
    step(OP_IDLE, '0, OP_IDLE, '0, "R7");
    step(OP_RD, SUB, OP_RD, TOP, "R5");            // both clear
    step(OP_WR, 17'h0FFFF, OP_WR, 17'h0FFFE, "R10");
    step(OP_WR, TOP - 17'd2, OP_WR, TOP - 17'd2, "R10");
    step(OP_IDLE, '0, OP_IDLE, '0, "R10");
    for (int i = 0; i < 600; i++) begin
      step(int'($urandom_range(0, 5)), pick_addr(),
           int'($urandom_range(0, 5)), pick_addr(), "R9");
    end
    step(OP_IDLE, '0, OP_IDLE, '0, "R9");
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule